// File: doc/BRIEF.md
# Segmented Scan Shift Controller

This controller runs the shift phase of a scan chain that has been cut into several segments by inserted test logic. Only one segment is loaded or unloaded at a time. Only that segment gets a shift clock enable, and every other segment keeps its clock held off, which limits switching activity during shift. Segments are served in rising index order. Each segment shifts for the programmed number of cycles. A one-cycle completion pulse follows the final shift cycle of the final segment.

Alongside the clock enables, a data-gating path selects what feeds each scan chain. Chains marked active take tester data. Chains in regions outside the current test are driven with constant zero. All gating applies only while scan enable is high. When scan enable is low (capture or functional operation), every segment clock is enabled and every chain passes its data through unchanged. Dropping scan enable in the middle of a sequence abandons the sequence.

Top module: `seg_scan_ctrl`

## Requirements
- R1: After reset, with scan enable high and no start pulse, no segment clock enable is high and the done flag is low.
- R2: While scan_en is low, all seg_clk_en bits are 1, every chain_sel bit is 1, and chain_si equals tester_si.
- R3: While scan_en is high and no sequence is running, all seg_clk_en bits are 0.
- R4: A shift_start pulse sampled with scan_en high starts a sequence. In the first cycle after that edge, seg_clk_en bit 0 is high. Segment k (bit k) is then enabled for exactly seg_len consecutive cycles, and segment k+1 follows immediately.
- R5: In every shift cycle, exactly one seg_clk_en bit is high.
- R6: done is high for exactly one cycle, the cycle right after the last shift cycle of segment seg_cnt-1, and it is low at all other times. During that cycle, seg_clk_en is all 0.
- R7: If scan_en falls during a sequence, the sequence is abandoned. done does not pulse, and when scan_en returns high the controller is idle with all enables 0.
- R8: While scan_en is high, chain_sel equals active_mask (bit c controls chain c). chain_si[c] equals tester_si[c] where the mask bit is 1 and is 0 where it is 0.
- R9: A shift_start pulse that arrives while a sequence is running is ignored.
- R10: seg_len and seg_cnt are captured at the start edge. Changes made during the sequence do not affect it.
- R11: If seg_len is 0 or seg_cnt is 0, no shift cycle occurs and done pulses in the first cycle after the start edge. A seg_cnt larger than MAX_SEGS is treated as MAX_SEGS.
- R12: A shift_start pulse sampled while scan_en is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scan_en | input | 1 | High selects scan shift, low selects capture or functional operation |
| shift_start | input | 1 | One-cycle request to begin a segment sequence |
| seg_len | input | LEN_W | Shift cycles per segment |
| seg_cnt | input | SEG_W | Number of segments to shift |
| active_mask | input | NUM_CHAINS | Per-chain flag: 1 means the chain is under test |
| tester_si | input | NUM_CHAINS | Scan data from the tester, one bit per chain |
| seg_clk_en | output | MAX_SEGS | Clock enable, one bit per segment |
| chain_sel | output | NUM_CHAINS | 1 passes tester data to the chain, 0 forces zero |
| chain_si | output | NUM_CHAINS | Scan-in data delivered to each chain |
| done | output | 1 | One-cycle pulse after the final shift cycle |

## Verification
The bench goes after the segment boundaries. An off-by-one beat counter would shorten or stretch a segment, or skip to the next index one cycle early. A wrong end test would pulse done a cycle late, or shift one segment too many. Degenerate programming is covered: a zero length or zero count must produce an immediate done instead of a 256-cycle wrap, and an oversized count must clamp rather than run into nonexistent segments. Two further cases are tested. An abort in the middle of a sequence must leave no stale state that later re-enables a segment or fires done. A start pulse or a length change during a run must not restart the sequence or stretch it.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_FIN   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/seg_seq.sv
module seg_seq
  import seg_scan_pkg::*;
#(
  parameter int MAX_SEGS = 8,
  parameter int LEN_W    = 8,
  localparam int SEG_W   = $clog2(MAX_SEGS + 1),
  localparam int IDX_W   = (MAX_SEGS > 1) ? $clog2(MAX_SEGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_en,
  input  logic             shift_start,
  input  logic [LEN_W-1:0] seg_len,
  input  logic [SEG_W-1:0] seg_cnt,
  output logic             shifting,
  output logic [IDX_W-1:0] seg_idx,
  output logic             fin
);
  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [LEN_W-1:0] beat_q, beat_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [SEG_W-1:0] cnt_q, cnt_d;
  logic [SEG_W-1:0] cnt_eff;
  logic             last_beat, last_seg;

  assign cnt_eff   = (seg_cnt > SEG_W'(MAX_SEGS)) ? SEG_W'(MAX_SEGS) : seg_cnt;
  assign last_beat = (beat_q == (len_q - LEN_W'(1)));
  assign last_seg  = ((SEG_W'(idx_q) + SEG_W'(1)) == cnt_q);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    beat_d  = beat_q;
    len_d   = len_q;
    cnt_d   = cnt_q;
    if (!scan_en) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (shift_start) begin
            len_d  = seg_len;
            cnt_d  = cnt_eff;
            idx_d  = '0;
            beat_d = '0;
            state_d = ((seg_len == '0) || (seg_cnt == '0)) ? ST_FIN : ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (last_beat) begin
            beat_d = '0;
            if (last_seg) state_d = ST_FIN;
            else          idx_d   = idx_q + IDX_W'(1);
          end else begin
            beat_d = beat_q + LEN_W'(1);
          end
        end
        ST_FIN:  state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      beat_q  <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      beat_q  <= beat_d;
      len_q   <= len_d;
      cnt_q   <= cnt_d;
    end
  end

  assign shifting = (state_q == ST_SHIFT);
  assign seg_idx  = idx_q;
  assign fin      = (state_q == ST_FIN);
endmodule

// File: rtl/seg_en_decode.sv
module seg_en_decode #(
  parameter int MAX_SEGS = 8,
  localparam int IDX_W   = (MAX_SEGS > 1) ? $clog2(MAX_SEGS) : 1
) (
  input  logic                scan_en,
  input  logic                shifting,
  input  logic [IDX_W-1:0]    seg_idx,
  output logic [MAX_SEGS-1:0] seg_clk_en
);
  for (genvar s = 0; s < MAX_SEGS; s++) begin : g_seg
    assign seg_clk_en[s] = ~scan_en | (shifting & (seg_idx == IDX_W'(s)));
  end
endmodule

// File: rtl/chain_data_gate.sv
module chain_data_gate #(
  parameter int NUM_CHAINS = 4
) (
  input  logic                  scan_en,
  input  logic [NUM_CHAINS-1:0] active_mask,
  input  logic [NUM_CHAINS-1:0] tester_si,
  output logic [NUM_CHAINS-1:0] chain_sel,
  output logic [NUM_CHAINS-1:0] chain_si
);
  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    assign chain_sel[c] = ~scan_en | active_mask[c];
    assign chain_si[c]  = chain_sel[c] & tester_si[c];
  end
endmodule

// File: rtl/seg_scan_ctrl.sv
module seg_scan_ctrl #(
  parameter int MAX_SEGS   = 8,
  parameter int LEN_W      = 8,
  parameter int NUM_CHAINS = 4,
  localparam int SEG_W     = $clog2(MAX_SEGS + 1),
  localparam int IDX_W     = (MAX_SEGS > 1) ? $clog2(MAX_SEGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scan_en,
  input  logic                  shift_start,
  input  logic [LEN_W-1:0]      seg_len,
  input  logic [SEG_W-1:0]      seg_cnt,
  input  logic [NUM_CHAINS-1:0] active_mask,
  input  logic [NUM_CHAINS-1:0] tester_si,
  output logic [MAX_SEGS-1:0]   seg_clk_en,
  output logic [NUM_CHAINS-1:0] chain_sel,
  output logic [NUM_CHAINS-1:0] chain_si,
  output logic                  done
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             shifting;
  logic [IDX_W-1:0] seg_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  seg_seq #(.MAX_SEGS(MAX_SEGS), .LEN_W(LEN_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .scan_en     (scan_en),
    .shift_start (shift_start),
    .seg_len     (seg_len),
    .seg_cnt     (seg_cnt),
    .shifting    (shifting),
    .seg_idx     (seg_idx),
    .fin         (done)
  );

  seg_en_decode #(.MAX_SEGS(MAX_SEGS)) u_dec (
    .scan_en    (scan_en),
    .shifting   (shifting),
    .seg_idx    (seg_idx),
    .seg_clk_en (seg_clk_en)
  );

  chain_data_gate #(.NUM_CHAINS(NUM_CHAINS)) u_gate (
    .scan_en     (scan_en),
    .active_mask (active_mask),
    .tester_si   (tester_si),
    .chain_sel   (chain_sel),
    .chain_si    (chain_si)
  );
endmodule

// File: rtl/seg_scan_ctrl_chk.sv
module seg_scan_ctrl_chk #(
  parameter int MAX_SEGS   = 8,
  parameter int NUM_CHAINS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scan_en,
  input logic [NUM_CHAINS-1:0] active_mask,
  input logic [MAX_SEGS-1:0]   seg_clk_en,
  input logic [NUM_CHAINS-1:0] chain_si,
  input logic                  done
);
  // R5
  shift_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |-> $onehot0(seg_clk_en));

  // R2
  capture_all_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |-> (&seg_clk_en));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (seg_clk_en == '0));

  // R7
  abort_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> !done);

  // R8
  idle_chain_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |-> ((chain_si & ~active_mask) == '0));

  // R4
  ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && $past(scan_en) && (seg_clk_en != '0) && ($past(seg_clk_en) != '0)
      && (seg_clk_en != $past(seg_clk_en)))
      |-> (seg_clk_en == ($past(seg_clk_en) << 1)));
endmodule

bind seg_scan_ctrl seg_scan_ctrl_chk #(.MAX_SEGS(MAX_SEGS), .NUM_CHAINS(NUM_CHAINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scan_en     (scan_en),
  .active_mask (active_mask),
  .seg_clk_en  (seg_clk_en),
  .chain_si    (chain_si),
  .done        (done)
);

// File: tb/seg_scan_ctrl_tb.sv
`timescale 1ns/1ps
module seg_scan_ctrl_tb;
  localparam int MAX_SEGS   = 8;
  localparam int LEN_W      = 8;
  localparam int NUM_CHAINS = 4;
  localparam int SEG_W      = $clog2(MAX_SEGS + 1);

  logic                  clk;
  logic                  rst_n;
  logic                  scan_en;
  logic                  shift_start;
  logic [LEN_W-1:0]      seg_len;
  logic [SEG_W-1:0]      seg_cnt;
  logic [NUM_CHAINS-1:0] active_mask;
  logic [NUM_CHAINS-1:0] tester_si;
  logic [MAX_SEGS-1:0]   seg_clk_en;
  logic [NUM_CHAINS-1:0] chain_sel;
  logic [NUM_CHAINS-1:0] chain_si;
  logic                  done;

  int checks = 0;
  int errors = 0;

  seg_scan_ctrl #(.MAX_SEGS(MAX_SEGS), .LEN_W(LEN_W), .NUM_CHAINS(NUM_CHAINS)) u_dut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .shift_start(shift_start),
    .seg_len(seg_len), .seg_cnt(seg_cnt), .active_mask(active_mask),
    .tester_si(tester_si), .seg_clk_en(seg_clk_en), .chain_sel(chain_sel),
    .chain_si(chain_si), .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic test_reset();
    scan_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(seg_clk_en == '0, "R1", 32'(seg_clk_en), 0);
      check(done == 1'b0, "R1", 32'(done), 0);
    end
  endtask

  task automatic test_capture();
    scan_en = 1'b0; active_mask = 4'b0000; tester_si = 4'b1011;
    @(negedge clk);
    check(seg_clk_en == '1, "R2", 32'(seg_clk_en), 32'hff);
    check(chain_sel == '1, "R2", 32'(chain_sel), 32'hf);
    check(chain_si == 4'b1011, "R2", 32'(chain_si), 32'hb);
  endtask

  task automatic test_gating();
    scan_en = 1'b1; active_mask = 4'b1010; tester_si = 4'b1111;
    @(negedge clk);
    check(chain_sel == 4'b1010, "R8", 32'(chain_sel), 32'ha);
    check(chain_si == 4'b1010, "R8", 32'(chain_si), 32'ha);
    check(seg_clk_en == '0, "R3", 32'(seg_clk_en), 0);
    tester_si = 4'b0110;
    @(negedge clk);
    check(chain_si == 4'b0010, "R8", 32'(chain_si), 32'h2);
    active_mask = 4'b0101;
    @(negedge clk);
    check(chain_si == 4'b0100, "R8", 32'(chain_si), 32'h4);
  endtask

  task automatic run_seq(input int len, input int cnt, input int eff, input bit poke,
                         input string req);
    int total;
    total = (len == 0 || cnt == 0) ? 0 : len * eff;
    @(negedge clk);
    scan_en = 1'b1; seg_len = LEN_W'(len); seg_cnt = SEG_W'(cnt); shift_start = 1'b1;
    for (int j = 0; j < total; j++) begin
      @(negedge clk);
      check(seg_clk_en == (MAX_SEGS'(1) << (j / len)), req, 32'(seg_clk_en),
            32'(MAX_SEGS'(1) << (j / len)));
      check($countones(seg_clk_en) == 1, "R5", 32'(seg_clk_en), 1);
      check(done == 1'b0, "R6", 32'(done), 0);
      shift_start = 1'b0;
      if (poke && j == 1) begin
        shift_start = 1'b1;
        seg_len = LEN_W'(len + 5);
        seg_cnt = SEG_W'(1);
      end
    end
    @(negedge clk);
    shift_start = 1'b0;
    check(done == 1'b1, req, 32'(done), 1);
    check(seg_clk_en == '0, "R6", 32'(seg_clk_en), 0);
    @(negedge clk);
    check(done == 1'b0, "R6", 32'(done), 0);
    check(seg_clk_en == '0, "R3", 32'(seg_clk_en), 0);
  endtask

  task automatic test_abort();
    @(negedge clk);
    scan_en = 1'b1; seg_len = 8'd3; seg_cnt = 4'd4; shift_start = 1'b1;
    repeat (5) @(negedge clk);
    shift_start = 1'b0;
    check(seg_clk_en == 8'h02, "R7", 32'(seg_clk_en), 2);
    scan_en = 1'b0;
    #0.1;
    check(seg_clk_en == '1, "R7", 32'(seg_clk_en), 32'hff);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check(done == 1'b0, "R7", 32'(done), 0);
    end
    scan_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(seg_clk_en == '0, "R7", 32'(seg_clk_en), 0);
      check(done == 1'b0, "R7", 32'(done), 0);
    end
  endtask

  task automatic test_start_in_capture();
    @(negedge clk);
    scan_en = 1'b0; seg_len = 8'd2; seg_cnt = 4'd2; shift_start = 1'b1;
    @(negedge clk);
    shift_start = 1'b0; scan_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(seg_clk_en == '0, "R12", 32'(seg_clk_en), 0);
      check(done == 1'b0, "R12", 32'(done), 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; scan_en = 1'b1; shift_start = 1'b0;
    seg_len = '0; seg_cnt = '0; active_mask = '0; tester_si = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    test_reset();
    test_capture();
    test_gating();
    run_seq(1, 1, 1, 1'b0, "R4");
    run_seq(3, 4, 4, 1'b0, "R4");
    run_seq(2, 8, 8, 1'b0, "R6");
    run_seq(4, 3, 3, 1'b1, "R9");
    run_seq(5, 2, 2, 1'b1, "R10");
    run_seq(0, 3, 3, 1'b0, "R11");
    run_seq(3, 0, 0, 1'b0, "R11");
    run_seq(1, 12, 8, 1'b0, "R11");
    test_abort();
    test_start_in_capture();
    run_seq(2, 2, 2, 1'b0, "R4");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule